// File: doc/BRIEF.md
# Load Store Byte Lane Unit

This unit sits between a processor core and a 32-bit, little-endian, byte-addressed memory with one cycle of read latency. The core presents an operation code, a base address, an optional signed offset and store data. The unit forms the effective address and steers byte and halfword data onto the correct lanes. It drives a word-aligned memory address with per-lane write enables and returns loads that are sign-extended or zero-extended to 32 bits.

The unit also owns the stack pointer. A push moves the pointer down by four and writes a word at the new position. A pop reads the word at the current position and then moves the pointer up by four. Halfword and word requests whose address is not naturally aligned are refused. The unit raises an error flag and leaves the memory idle.

Top module: `lsu_lane_steer`

## Requirements
- R1: The effective address is `base + imm` when `imm_en` is 1, and `base` alone otherwise. `mem_addr` carries that address with bits [1:0] cleared, in the same cycle as the request.
- R2: A signed byte load (op 1) returns the byte in lane `addr[1:0]`, sign-extended. A signed halfword load (op 2) returns lanes 1:0 when `addr[1]` is 0 and lanes 3:2 when it is 1, sign-extended. Lane k occupies data bits [8k+7:8k].
- R3: Unsigned byte (op 3) and unsigned halfword (op 4) loads select lanes as in R2 and zero-extend.
- R4: A word load (op 5) returns all 32 bits of the addressed word unchanged.
- R5: A store drives `mem_we`. A byte store (op 6) enables only lane `addr[1:0]` and repeats data[7:0] on all four lanes. A halfword store (op 7) enables lanes 1:0 or 3:2 and repeats data[15:0] twice. A word store (op 8) enables all four lanes. `mem_be` is 0 whenever `mem_we` is 0.
- R6: A push (op 9) writes `st_data` to all four lanes at address (sp-4) with bits [1:0] cleared. `sp_out` then decreases by 4 at the next clock edge.
- R7: A pop (op 10) reads the word at sp with bits [1:0] cleared. It returns that word like a word load, and `sp_out` increases by 4 at the next clock edge.
- R8: On reset, `sp_out` is 32'h7fffffff and `ld_valid` is 0.
- R9: A halfword access with `addr[0]` set, or a word access with `addr[1:0]` not zero, raises `misalign` in the same cycle. It leaves `mem_en` low and produces no `ld_valid`. Push and pop are never flagged.
- R10: After an accepted load or pop, `ld_valid` is 1 and `ld_data` holds the result in the following cycle. After a cycle with no load, `ld_valid` is 0. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| base | input | 32 | Base address |
| imm | input | 32 | Signed offset |
| imm_en | input | 1 | Add the offset to the base |
| st_data | input | 32 | Store or push data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Lane write enables |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, one cycle after the request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned request refused |
| sp_out | output | 32 | Current stack pointer |

## Verification
One word with set high bits in its lower two bytes is read back through every lane offset and every load width. A negative byte and a positive byte land in different lanes, which separates sign extension from zero extension and shows whether lane selection is wrong. Byte and halfword stores to odd lanes, reached through a negative offset, show whether enables and replication are correct. Their readback shows that neighbouring lanes were left untouched. A run of pushes followed by pops checks the pointer arithmetic from the unaligned reset value and the last-in, first-out order. Odd and misaligned addresses are then sent for each width.

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
  parameter logic [31:0] SP_TOP = 32'h7fff_ffff
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [3:0]  req_op,
  input  logic [31:0] base,
  input  logic [31:0] imm,
  input  logic        imm_en,
  input  logic [31:0] st_data,
  output logic        mem_en,
  output logic        mem_we,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        ld_valid,
  output logic [31:0] ld_data,
  output logic        misalign,
  output logic [31:0] sp_out
);
  localparam logic [3:0] OP_LDSB = 4'd1, OP_LDSH = 4'd2, OP_LDUB = 4'd3,
                         OP_LDUH = 4'd4, OP_LDW  = 4'd5, OP_STB  = 4'd6,
                         OP_STH  = 4'd7, OP_STW  = 4'd8, OP_PUSH = 4'd9,
                         OP_POP  = 4'd10;
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  logic        is_ld, is_st, sgn;
  logic [1:0]  sz;
  logic        push, pop, go;
  logic [31:0] sp_q, ea, addr;
  logic        rv_q, rsgn_q;
  logic [1:0]  rsz_q, rlane_q;
  logic [7:0]  bsel;
  logic [15:0] hsel;

  always_comb begin
    is_ld = 1'b0; is_st = 1'b0; sgn = 1'b0; sz = SZ_W;
    case (req_op)
      OP_LDSB: begin is_ld = 1'b1; sgn = 1'b1; sz = SZ_B; end
      OP_LDSH: begin is_ld = 1'b1; sgn = 1'b1; sz = SZ_H; end
      OP_LDUB: begin is_ld = 1'b1; sz = SZ_B; end
      OP_LDUH: begin is_ld = 1'b1; sz = SZ_H; end
      OP_LDW, OP_POP: is_ld = 1'b1;
      OP_STB:  begin is_st = 1'b1; sz = SZ_B; end
      OP_STH:  begin is_st = 1'b1; sz = SZ_H; end
      OP_STW, OP_PUSH: is_st = 1'b1;
      default: ;
    endcase
  end

  assign push = req_valid && req_op == OP_PUSH;
  assign pop  = req_valid && req_op == OP_POP;
  assign ea   = imm_en ? base + imm : base;
  assign addr = push ? sp_q - 32'd4 : (pop ? sp_q : ea);

  assign misalign = req_valid && !push && !pop && (is_ld || is_st) &&
                    ((sz == SZ_H && addr[0]) || (sz == SZ_W && addr[1:0] != 2'b00));
  assign go       = req_valid && (is_ld || is_st) && !misalign;

  assign mem_en   = go;
  assign mem_we   = go && is_st;
  assign mem_addr = {addr[31:2], 2'b00};

  always_comb begin
    case (sz)
      SZ_B:    begin mem_be = 4'b0001 << addr[1:0]; mem_wdata = {4{st_data[7:0]}}; end
      SZ_H:    begin mem_be = addr[1] ? 4'b1100 : 4'b0011; mem_wdata = {2{st_data[15:0]}}; end
      default: begin mem_be = 4'b1111; mem_wdata = st_data; end
    endcase
    if (!mem_we) mem_be = 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= SP_TOP;
      rv_q    <= 1'b0;
      rsgn_q  <= 1'b0;
      rsz_q   <= SZ_W;
      rlane_q <= 2'b00;
    end else begin
      rv_q <= go && is_ld;
      if (go && is_ld) begin
        rsgn_q  <= sgn;
        rsz_q   <= sz;
        rlane_q <= (push || pop) ? 2'b00 : addr[1:0];
      end
      if (push)     sp_q <= sp_q - 32'd4;
      else if (pop) sp_q <= sp_q + 32'd4;
    end
  end

  assign bsel = mem_rdata[8*rlane_q +: 8];
  assign hsel = rlane_q[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (rsz_q)
      SZ_B:    ld_data = {{24{rsgn_q & bsel[7]}}, bsel};
      SZ_H:    ld_data = {{16{rsgn_q & hsel[15]}}, hsel};
      default: ld_data = mem_rdata;
    endcase
  end

  assign ld_valid = rv_q;
  assign sp_out   = sp_q;

  p_no_access_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_en);
  p_load_result_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> ld_valid);
  p_push_moves_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_PUSH) |=> sp_out == $past(sp_out) - 32'd4);
  p_pop_moves_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_POP) |=> sp_out == $past(sp_out) + 32'd4);
  p_be_only_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> mem_be == 4'b0000);
  p_byte_store_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_op == OP_STB) |-> $countones(mem_be) == 1);
endmodule

// File: tb/sim_lsu_lane_steer.sv
module sim_lsu_lane_steer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, imm_en = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic [31:0] base = 0, imm = 0, st_data = 0;
  logic mem_en, mem_we, ld_valid, misalign;
  logic [3:0] mem_be;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data, sp_out;

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] emem [64];
  logic [31:0] erd = 0;
  logic [7:0]  rmem [int unsigned];
  logic [31:0] rsp = 32'h7fff_ffff;

  always #4 clk = ~clk;

  lsu_lane_steer u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base(base), .imm(imm), .imm_en(imm_en), .st_data(st_data), .mem_en(mem_en),
    .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .misalign(misalign), .sp_out(sp_out));

  assign mem_rdata = erd;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) emem[mem_addr[7:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else erd <= emem[mem_addr[7:2]];
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] rb(input logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : 8'h00;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [31:0] b, input logic [31:0] im,
                       input logic ie, input logic [31:0] sd, input string r);
    logic [31:0] a, ew, eld;
    logic [3:0] ebe;
    logic ld, st, bad;
    int nb;
    @(negedge clk);
    req_valid = 1'b1; req_op = o; base = b; imm = im; imm_en = ie; st_data = sd;
    #1;
    a = ie ? b + im : b;
    if (o == 4'd9) a = rsp - 4;
    if (o == 4'd10) a = rsp;
    if (o == 4'd9 || o == 4'd10) a[1:0] = 2'b00;
    ld = (o >= 4'd1 && o <= 4'd5) || o == 4'd10;
    st = (o >= 4'd6 && o <= 4'd9);
    nb = (o == 4'd1 || o == 4'd3 || o == 4'd6) ? 1 : (o == 4'd2 || o == 4'd4 || o == 4'd7) ? 2 : 4;
    bad = (ld || st) && ((nb == 2 && a[0]) || (nb == 4 && a[1:0] != 0));
    chk({r, " R9 misalign"}, {31'd0, misalign}, {31'd0, bad});
    chk({r, " R9 mem_en"}, {31'd0, mem_en}, {31'd0, (ld || st) && !bad});
    if ((ld || st) && !bad) chk({r, " R1 mem_addr"}, mem_addr, {a[31:2], 2'b00});
    ebe = 4'd0;
    if (st && !bad) begin
      for (int k = 0; k < nb; k++) begin
        ebe[a[1:0] + k] = 1'b1;
        rmem[{a[31:2], 2'b00} + a[1:0] + k] = sd[8*k +: 8];
      end
      for (int k = 0; k < 4; k++)
        if (ebe[k]) chk({r, " R5 lane data"}, {24'd0, mem_wdata[8*k +: 8]}, {24'd0, sd[8*(k % nb) +: 8]});
    end
    chk({r, " R5 mem_be"}, {28'd0, mem_be}, {28'd0, ebe});
    ew = 0;
    for (int k = 0; k < nb; k++) ew[8*k +: 8] = rb(a + k);
    eld = ew;
    if (o == 4'd1) eld = {{24{ew[7]}}, ew[7:0]};
    if (o == 4'd2) eld = {{16{ew[15]}}, ew[15:0]};
    if (o == 4'd9) rsp = rsp - 4;
    if (o == 4'd10) rsp = rsp + 4;
    @(negedge clk);
    req_valid = 1'b0; req_op = 4'd0;
    #1;
    chk({r, " R10 ld_valid"}, {31'd0, ld_valid}, {31'd0, ld && !bad});
    if (ld && !bad) chk({r, " R2 R3 R4 R7 ld_data"}, ld_data, eld);
    chk({r, " R6 R7 sp_out"}, sp_out, rsp);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) emem[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset sp", sp_out, 32'h7fff_ffff);
    chk("R8 reset ld_valid", {31'd0, ld_valid}, 0);
    rst_n = 1'b1;
    do_op(4'd8, 32'h1000_0000, 0, 0, 32'h8421_F0C3, "R5 stw");
    do_op(4'd5, 32'h1000_0000, 0, 0, 0, "R4 ldw");
    for (int k = 0; k < 4; k++) begin
      do_op(4'd1, 32'h1000_0000, k, 1, 0, "R2 ldsb");
      do_op(4'd3, 32'h1000_0000, k, 1, 0, "R3 ldub");
    end
    for (int k = 0; k < 4; k += 2) begin
      do_op(4'd2, 32'h1000_0000, k, 1, 0, "R2 ldsh");
      do_op(4'd4, 32'h1000_0000, k, 1, 0, "R3 lduh");
    end
    do_op(4'd6, 32'h1000_0014, -32'sd3, 1, 32'h0000_00A5, "R1 stb negative offset");
    do_op(4'd6, 32'h1000_0012, 0, 0, 32'hFFFF_FF3C, "R5 stb lane2");
    do_op(4'd3, 32'h1000_0011, 0, 0, 0, "R3 ldub back");
    do_op(4'd1, 32'h1000_0012, 0, 0, 0, "R2 ldsb positive");
    do_op(4'd5, 32'h1000_0010, 0, 0, 0, "R5 word after bytes");
    do_op(4'd7, 32'h1000_0020, 32'd2, 1, 32'h1234_80FE, "R5 sth upper");
    do_op(4'd7, 32'h1000_0020, 0, 1, 32'h0000_7F01, "R5 sth lower");
    do_op(4'd5, 32'h1000_0020, 0, 0, 0, "R4 word after halves");
    do_op(4'd2, 32'h1000_0022, 0, 0, 0, "R2 ldsh neg");
    do_op(4'd5, 32'h1000_0001, 0, 0, 0, "R9 ldw odd");
    do_op(4'd4, 32'h1000_0003, 0, 0, 0, "R9 lduh odd");
    do_op(4'd8, 32'h1000_0002, 0, 0, 32'hDEAD_BEEF, "R9 stw half aligned");
    do_op(4'd7, 32'h1000_0000, 32'd1, 1, 32'hBEEF, "R9 sth odd");
    do_op(4'd5, 32'h1000_0000, 0, 0, 0, "R9 word untouched");
    do_op(4'd9, 0, 0, 0, 32'h1111_1111, "R6 push1");
    do_op(4'd9, 0, 0, 0, 32'h2222_2222, "R6 push2");
    do_op(4'd9, 0, 0, 0, 32'h8333_3333, "R6 push3");
    do_op(4'd10, 0, 0, 0, 0, "R7 pop3");
    do_op(4'd10, 0, 0, 0, 0, "R7 pop2");
    do_op(4'd10, 0, 0, 0, 0, "R7 pop1");
    do_op(4'd0, 32'h1000_0000, 0, 0, 0, "R10 nop");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule